// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block is a free-running master time counter. Its count rate stays at a fixed nominal value (6.144 MHz) whatever the reference clock it runs from. Two ratio registers hold a numerator and a denominator. On every reference clock the numerator is added to a residue. When the residue reaches the denominator, the count steps by one and the denominator is taken back out of the residue. The average count rate is therefore the reference frequency times numerator over denominator. A 19.2 MHz reference uses 8/25, 38.4 MHz uses 4/25, 20 MHz uses 192/625, 26 MHz uses 384/1625 and 27 MHz uses 256/1125.

Software reaches the block through a simple word-wide register port. The two ratio words keep every bit written to them, but only their low 12 bits set the ratio. The full count is two data words wide. It is driven on a parallel output for downstream timers. Software can also read it as two halves: a read of the low half captures the high half at the same instant, so a later read of the high half gives a consistent pair.

Top module: `rtcnt_top`

## Requirements
- R1: After reset the count is zero, the numerator word reads 4 and the denominator word reads 25, so the counter runs at 4/25 of the reference.
- R2: With a nonzero denominator D and a numerator N no larger than D, the count advances by exactly floor(k*N/D) over k clocks that start with a cleared residue. For example, 8/25 gives 80 steps in 250 clocks.
- R3: The numerator word is at offset 0x10 and the denominator word at 0x14. A write stores the whole word and a read returns it unchanged. Only bits [11:0] set the ratio, so bits above 11 have no effect on the rate.
- R4: A write to either ratio word clears the residue. In that same clock the count does not step.
- R5: While the denominator field is zero, the count holds its value.
- R6: A numerator larger than the denominator is treated as equal to it, so the count steps exactly once per clock.
- R7: A read of offset 0x00 returns the low half of the count as it stood before that clock edge, and in the same edge captures the high half. A read of offset 0x04 returns the captured high half, not the live one.
- R8: Read data appears on the clock edge that samples the read enable and holds until the next read. A read of any other offset returns zero.
- R9: The count never decreases, and from one clock to the next it changes by zero or one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the accumulator advances on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| countOut | output | 2*DATA_W | Live count for downstream timers |

## Verification
Two functions can land on the same edge: a write to a ratio word, and the accumulator step that would otherwise have carried. The bench sets a 1/2 ratio so that the residue sits at one every other clock. It then rewrites the denominator on exactly the edge where a step is due, and reads the count on the following edges. The clear must win: the step is skipped and the alternating pattern restarts from a zero residue. Random ratio writes mixed with reads then reach the same collision at many other residue values, and every read is compared with a bench model of the requirements.

// File: rtl/rtcnt_pkg.sv
`timescale 1ns/1ps
package rtcnt_pkg;
  // Strobes from the control half to the accumulator datapath.
  typedef struct packed {
    logic clrResidue; // ratio word written this cycle
    logic runEn;      // denominator field nonzero
  } accStrobes_t;
endpackage

// File: rtl/rtcnt_ctrl.sv
`timescale 1ns/1ps
module rtcnt_ctrl
  import rtcnt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int RATIO_W = 12,
  parameter int DEF_NUM = 4,
  parameter int DEF_DEN = 25
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [2*DATA_W-1:0]   count,
  output logic [RATIO_W-1:0]    ratioNum,
  output logic [RATIO_W-1:0]    ratioDen,
  output accStrobes_t           strobes
);
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_NUM    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_DEN    = ADDR_W'(8'h14);

  logic [DATA_W-1:0] numWord, denWord, shadowHi;
  logic hitNum, hitDen, readLo, unmapped;

  assign hitNum   = wrEn && (addr == OFS_NUM);
  assign hitDen   = wrEn && (addr == OFS_DEN);
  assign readLo   = rdEn && (addr == OFS_CNT_LO);
  assign unmapped = !(addr == OFS_CNT_LO || addr == OFS_CNT_HI ||
                      addr == OFS_NUM || addr == OFS_DEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numWord <= DATA_W'(DEF_NUM);
      denWord <= DATA_W'(DEF_DEN);
    end else begin
      if (hitNum) numWord <= wrData;
      if (hitDen) denWord <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      shadowHi <= '0;
    end else if (rdEn) begin
      unique case (addr)
        OFS_CNT_LO: begin
          rdData   <= count[DATA_W-1:0];
          shadowHi <= count[2*DATA_W-1:DATA_W];
        end
        OFS_CNT_HI: rdData <= shadowHi;
        OFS_NUM:    rdData <= numWord;
        OFS_DEN:    rdData <= denWord;
        default:    rdData <= '0;
      endcase
    end
  end

  assign ratioNum           = numWord[RATIO_W-1:0];
  assign ratioDen           = denWord[RATIO_W-1:0];
  assign strobes.clrResidue = hitNum || hitDen;
  assign strobes.runEn      = (ratioDen != '0);

  // R7: the captured high half moves only on a low-half read
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !readLo |=> $stable(shadowHi));
  // R8: reads of unmapped offsets return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == '0));
  // R8: read data holds between reads
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/rtcnt_accum.sv
`timescale 1ns/1ps
module rtcnt_accum
  import rtcnt_pkg::*;
#(
  parameter int RATIO_W = 12,
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioNum,
  input  logic [RATIO_W-1:0] ratioDen,
  input  accStrobes_t        strobes,
  output logic [COUNT_W-1:0] count
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] residue, effNum;
  logic [SUM_W-1:0]   sum, remain;
  logic               carry;

  // A numerator above the denominator is clamped to it.
  assign effNum = (ratioNum > ratioDen) ? ratioDen : ratioNum;
  assign sum    = {1'b0, residue} + {1'b0, effNum};
  assign carry  = (sum >= {1'b0, ratioDen});
  assign remain = sum - {1'b0, ratioDen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residue <= '0;
      count   <= '0;
    end else if (strobes.clrResidue) begin
      residue <= '0;
    end else if (strobes.runEn) begin
      if (carry) begin
        residue <= remain[RATIO_W-1:0];
        count   <= count + COUNT_W'(1);
      end else begin
        residue <= sum[RATIO_W-1:0];
      end
    end
  end

  // R9: monotonic, at most one step per clock
  a_r9_step_le_one: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count) || count == $past(count) + COUNT_W'(1)));
  // R4: a ratio write clears the residue and blocks the step
  a_r4_clear_no_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrResidue |=> (residue == '0 && $stable(count)));
  // R5: zero denominator freezes the count
  a_r5_den_zero_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runEn |=> $stable(count));
  // R6: the residue stays below the denominator even with a large numerator
  a_r6_residue_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runEn |-> (residue < ratioDen));
endmodule

// File: rtl/rtcnt_top.sv
`timescale 1ns/1ps
module rtcnt_top
  import rtcnt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int RATIO_W = 12,
  parameter int DEF_NUM = 4,
  parameter int DEF_DEN = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] countOut
);
  localparam int COUNT_W = 2 * DATA_W;

  logic [RATIO_W-1:0] ratioNum, ratioDen;
  accStrobes_t        strobes;

  rtcnt_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W),
    .DEF_NUM(DEF_NUM), .DEF_DEN(DEF_DEN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .count(countOut),
    .ratioNum(ratioNum), .ratioDen(ratioDen), .strobes(strobes)
  );

  rtcnt_accum #(
    .RATIO_W(RATIO_W), .COUNT_W(COUNT_W)
  ) accum_i (
    .clk(clk), .rstN(rstN), .ratioNum(ratioNum), .ratioDen(ratioDen),
    .strobes(strobes), .count(countOut)
  );
endmodule

// File: tb/rtcnt_top_tb_top.sv
`timescale 1ns/1ps
module rtcnt_top_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_LO = 8'h00, A_HI = 8'h04, A_NUM = 8'h10,
                            A_DEN = 8'h14, A_BAD = 8'h08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [CW-1:0] countOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtcnt_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .countOut(countOut)
  );

  // Requirement model
  logic [DW-1:0] mNum, mDen, mShadow, mRd;
  logic [11:0]   mRes;
  logic [CW-1:0] mCount;

  function automatic logic [12:0] effNumOf(logic [11:0] n, logic [11:0] d);
    return (n > d) ? {1'b0, d} : {1'b0, n};
  endfunction

  always @(posedge clk) begin
    logic [12:0] s;
    if (!rstN) begin
      mNum = DW'(4); mDen = DW'(25); mRes = '0; mCount = '0;
      mShadow = '0; mRd = '0;
    end else begin
      if (rdEn) begin
        if (addr == A_LO) begin mRd = mCount[DW-1:0]; mShadow = mCount[CW-1:DW]; end
        else if (addr == A_HI) mRd = mShadow;
        else if (addr == A_NUM) mRd = mNum;
        else if (addr == A_DEN) mRd = mDen;
        else mRd = '0;
      end
      if (wrEn && (addr == A_NUM || addr == A_DEN)) begin
        if (addr == A_NUM) mNum = wrData; else mDen = wrData;
        mRes = '0;
      end else if (mDen[11:0] != 12'd0) begin
        s = {1'b0, mRes} + effNumOf(mNum[11:0], mDen[11:0]);
        if (s >= {1'b0, mDen[11:0]}) begin
          mRes = 12'(s - {1'b0, mDen[11:0]});
          mCount = mCount + CW'(1);
        end else mRes = s[11:0];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bus operations start at a negedge and consume one rising edge each.
  task automatic busWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [DW-1:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, c0, c1, hiA;
    logic [11:0] rn, rd;
    void'($urandom(32'h5EED_0C7A));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count in reset", 64'(countOut), 64'd0);
    chk("R8 rdData in reset", 64'(rdData), 64'd0);
    rstN = 1'b1;
    busRead(A_NUM, v); chk("R1 default numerator", 64'(v), 64'd4);
    busRead(A_DEN, v); chk("R1 default denominator", 64'(v), 64'd25);
    busRead(A_LO, v);  chk("R1 count after reset", 64'(v), 64'(mRd));

    // R2 / R3: 8/25 with upper bits set, readback of whole words
    busWrite(A_NUM, 16'hA008);
    busWrite(A_DEN, 16'h5019);
    busRead(A_LO, c0);
    idle(249);
    busRead(A_LO, c1);
    chk("R2 8/25 over 250 clocks", 64'(c1 - c0), 64'd80);
    busRead(A_NUM, v); chk("R3 numerator word readback", 64'(v), 64'h A008);
    busRead(A_DEN, v); chk("R3 denominator word readback", 64'(v), 64'h5019);

    // R2: 192/625 over 625 clocks
    busWrite(A_NUM, 16'd192);
    busWrite(A_DEN, 16'd625);
    busRead(A_LO, c0);
    idle(624);
    busRead(A_LO, c1);
    chk("R2 192/625 over 625 clocks", 64'(c1 - c0), 64'd192);

    // R4: ratio write on the edge where a step is due
    busWrite(A_NUM, 16'd1);
    busWrite(A_DEN, 16'd2);
    busRead(A_LO, c0);
    busWrite(A_DEN, 16'd2);
    busRead(A_LO, c1); chk("R4 write edge does not step", 64'(c1), 64'(c0));
    busRead(A_LO, c1); chk("R4 residue restarts from zero", 64'(c1), 64'(c0));
    busRead(A_LO, c1); chk("R4 step after two clocks", 64'(c1), 64'(c0 + 1'b1));

    // R5: zero denominator holds
    busWrite(A_DEN, 16'hF000);
    busRead(A_LO, c0);
    idle(50);
    busRead(A_LO, c1); chk("R5 zero denominator holds", 64'(c1), 64'(c0));

    // R6: numerator above denominator clamps
    busWrite(A_NUM, 16'd30);
    busWrite(A_DEN, 16'd20);
    busRead(A_LO, c0);
    idle(9);
    busRead(A_LO, c1); chk("R6 clamp to one step per clock", 64'(c1 - c0), 64'd10);

    // R8: unmapped read
    busRead(A_BAD, v); chk("R8 unmapped reads zero", 64'(v), 64'd0);

    // R7: high half capture across a low-half rollover
    busWrite(A_NUM, 16'd1);
    busWrite(A_DEN, 16'd1);
    while (mCount[DW-1:0] != 16'hFFE0) @(negedge clk);
    busRead(A_LO, v); chk("R7 low half value", 64'(v), 64'(mRd));
    hiA = mCount[CW-1:DW];
    idle(40);
    chk("R9 rollover carried into high half", 64'(countOut[CW-1:DW]), 64'(hiA + 1'b1));
    busRead(A_HI, v); chk("R7 high half is captured value", 64'(v), 64'(hiA));
    busRead(A_LO, v);
    busRead(A_HI, v); chk("R7 high half after new capture", 64'(v), 64'(hiA + 1'b1));

    // Random phase: ratio writes mixed with reads, compared against the model
    for (int k = 0; k < 1500; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) begin
        rd = ($urandom_range(0, 9) == 0) ? 12'd0 : 12'($urandom_range(1, 4095));
        busWrite(A_DEN, {4'($urandom), rd});
      end else if (op == 1) begin
        rn = 12'($urandom_range(0, 4095));
        busWrite(A_NUM, {4'($urandom), rn});
      end else if (op <= 7) begin
        logic [AW-1:0] a;
        case (op)
          2, 3: a = A_LO;
          4:    a = A_HI;
          5:    a = A_NUM;
          6:    a = A_DEN;
          default: a = A_BAD;
        endcase
        busRead(a, v);
        chk("R2 R3 R7 R8 random read", 64'(v), 64'(mRd));
      end else begin
        idle(int'($urandom_range(0, 20)));
        chk("R9 live count matches model", 64'(countOut), 64'(mCount));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule